// File: doc/BRIEF.md
# Block Transfer Byte-Packing Sequencer

This block sits between a 16-bit word FIFO and a byte-wide card data port and moves the payload of a multi-block data transfer. Software programs a block length in bytes and a number of blocks. A transfer-active input, qualified by a direction bit, then lets the sequencer stream bytes one per clock over a valid/ready handshake. On receive it packs card bytes into FIFO words. On transmit it unpacks FIFO words into card bytes.

Two bytes share a FIFO word, and the earlier byte always sits in bits 7:0. When a block has an odd length, its last byte takes a word of its own, with bits 15:8 left zero on receive and never sent on transmit. A byte down-counter and a block down-counter track progress, and both can be read back live. The sequencer holds off on receive while the FIFO fill is above a programmable almost-full level, and on transmit while the FIFO is empty. After the last byte of the last block it reloads both counters, stops, and pulses a done flag. The neighbouring status logic records that flag as bit 3 of its status word.

Top module: `xfer_pack_seq`

## Requirements
- R1: A block-length write with field value v (bits 10:0 of `cfg_field`) sets the programmed length and the live byte counter to v+1. `len_live` shows v+1 from the next cycle.
- R2: A block-count write with field value v sets the programmed count and the live block counter to v+1. It also reloads the live byte counter with the programmed length.
- R3: On receive, the first byte of a word is stored in bits 7:0 and the second byte in bits 15:8. If the block's last byte falls in the low half, it is pushed alone with bits 15:8 equal to 0.
- R4: On transmit, bits 7:0 of the FIFO head word go out first. Bits 15:8 go out next only if the block still needs a byte; otherwise the word is popped after its low byte.
- R5: On receive, `card_rx_ready` is low while `fifo_fill` is greater than `af_level`, unless a low byte is already held waiting for its partner.
- R6: On transmit, `card_tx_valid` is low while the FIFO is empty.
- R7: When a byte completes a block that is not the last one, the block counter decrements by one and the byte counter reloads to the programmed length.
- R8: When the last byte of the last block moves, both counters reload to their programmed values. `xfer_done` is high for exactly one cycle, and no further byte moves until `xfer_active` falls and rises again.
- R9: No byte moves while `xfer_active` is low. A transfer starts in the cycle after `xfer_active` rises; `xfer_dir`=1 selects receive and 0 selects transmit.
- R10: A host push into a full FIFO (32 words) is ignored, and a host pop from an empty FIFO is ignored. A host push during a live receive is ignored, and a host pop during a live transmit is ignored.
- R11: `len_live` and `cnt_live` always return the live down-counters, never the programmed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_len_we | input | 1 | Block-length register write strobe |
| cfg_cnt_we | input | 1 | Block-count register write strobe |
| cfg_field | input | 11 | Write data for either register (value minus one) |
| len_live | output | 12 | Live byte down-counter |
| cnt_live | output | 12 | Live block down-counter |
| host_push | input | 1 | Host writes a word into the FIFO |
| host_wdata | input | 16 | Word written by the host |
| host_pop | input | 1 | Host removes the head word |
| host_rdata | output | 16 | FIFO head word |
| fifo_fill | output | 6 | Number of words held |
| af_level | input | 5 | Almost-full level for receive pacing |
| xfer_active | input | 1 | Transfer enable, level |
| xfer_dir | input | 1 | 1 = card to FIFO, 0 = FIFO to card |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_data | input | 8 | Byte from the card |
| card_rx_ready | output | 1 | Sequencer accepts the card byte |
| card_tx_valid | output | 1 | Sequencer offers a byte |
| card_tx_data | output | 8 | Byte to the card |
| card_tx_ready | input | 1 | Card accepts the byte |
| xfer_done | output | 1 | One-cycle pulse when the transfer completes |

## Verification
The bench aims at odd block lengths in both directions. A design that mishandled them would leave a stale high byte in the last receive word, or send a spurious byte on transmit and drift out of step. It fills the FIFO up to the almost-full level while a half word is held: a design that checked the level on every byte would stall in the middle of a word, and one that ignored the level would overrun the FIFO. It follows the live counters byte by byte across block boundaries, which catches a block count that decrements one byte early and a byte counter that reloads from the wrong source. It also checks that the sequencer goes quiet after completion, and that host accesses are ignored while the sequencer owns that side of the FIFO; a design that got these wrong would corrupt data or keep streaming.

// File: rtl/xps_pkg.sv
package xps_pkg;

    // Width of the programmed length/count field (value minus one).
    parameter int XPS_FIELD_W = 11;
    // Words held by the packing FIFO; must be a power of two.
    parameter int XPS_DEPTH   = 32;
    parameter int XPS_BYTE_W  = 8;
    parameter int XPS_WORD_W  = 2 * XPS_BYTE_W;

    typedef enum logic [1:0] {
        XPS_IDLE = 2'd0,
        XPS_RX   = 2'd1,
        XPS_TX   = 2'd2
    } xps_mode_e;

endpackage

// File: rtl/xps_fifo.sv
module xps_fifo
    import xps_pkg::*;
#(
    parameter int DEPTH  = XPS_DEPTH,
    parameter int WORD_W = XPS_WORD_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic [WORD_W-1:0]           push_data,
    input  logic                        pop,
    output logic [WORD_W-1:0]           head,
    output logic [$clog2(DEPTH):0]      fill
);

    localparam int PTR_W  = $clog2(DEPTH);
    localparam int FILL_W = PTR_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0]  wr_ptr;
        logic [PTR_W-1:0]  rd_ptr;
        logic [FILL_W-1:0] fill;
    } fifo_state_t;

    fifo_state_t        st_q, st_d;
    logic [WORD_W-1:0]  mem_q [DEPTH];
    logic               do_push, do_pop;

    assign do_push = push && (st_q.fill < FILL_W'(DEPTH));
    assign do_pop  = pop  && (st_q.fill != '0);

    always_comb begin
        st_d = st_q;
        if (do_push) begin
            st_d.wr_ptr = st_q.wr_ptr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd_ptr = st_q.rd_ptr + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.fill = st_q.fill + 1'b1;
            2'b01:   st_d.fill = st_q.fill - 1'b1;
            default: st_d.fill = st_q.fill;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[st_q.wr_ptr] <= push_data;
        end
    end

    assign head = mem_q[st_q.rd_ptr];
    assign fill = st_q.fill;

    // R10: a push into a full FIFO leaves it full and unchanged in size
    assert_full_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == FILL_W'(DEPTH) && push && !pop) |=> (fill == FILL_W'(DEPTH)));

    // R10: a pop on an empty FIFO does not wrap the fill count
    assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0 && pop && !push) |=> (fill == '0));

endmodule

// File: rtl/xps_counters.sv
module xps_counters
    import xps_pkg::*;
#(
    parameter int FIELD_W = XPS_FIELD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 len_we,
    input  logic                 cnt_we,
    input  logic [FIELD_W-1:0]   field,
    input  logic                 byte_fire,
    output logic [FIELD_W:0]     len_live,
    output logic [FIELD_W:0]     cnt_live,
    output logic                 last_byte,
    output logic                 blk_end,
    output logic                 done_pulse
);

    localparam int CNT_W = FIELD_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] len_prog;
        logic [CNT_W-1:0] cnt_prog;
        logic [CNT_W-1:0] len_cnt;
        logic [CNT_W-1:0] blk_cnt;
        logic             done;
    } cnt_state_t;

    cnt_state_t       st_q, st_d;
    logic [CNT_W-1:0] field_plus1;
    logic             last_blk;

    assign field_plus1 = {1'b0, field} + 1'b1;
    // A counter at 1 (or 0 before any programming) means this is the final step.
    assign last_byte   = (st_q.len_cnt <= CNT_W'(1));
    assign last_blk    = (st_q.blk_cnt <= CNT_W'(1));
    assign blk_end     = byte_fire && last_byte && last_blk;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;

        if (byte_fire) begin
            if (last_byte) begin
                st_d.len_cnt = st_q.len_prog;
                if (last_blk) begin
                    st_d.blk_cnt = st_q.cnt_prog;
                    st_d.done    = 1'b1;
                end else begin
                    st_d.blk_cnt = st_q.blk_cnt - 1'b1;
                end
            end else begin
                st_d.len_cnt = st_q.len_cnt - 1'b1;
            end
        end

        // Register writes take priority over counting.
        if (len_we) begin
            st_d.len_prog = field_plus1;
            st_d.len_cnt  = field_plus1;
        end
        if (cnt_we) begin
            st_d.cnt_prog = field_plus1;
            st_d.blk_cnt  = field_plus1;
            st_d.len_cnt  = st_d.len_prog;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign len_live   = st_q.len_cnt;
    assign cnt_live   = st_q.blk_cnt;
    assign done_pulse = st_q.done;

    // R7: end of a non-final block steps the block counter and reloads bytes
    assert_blk_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_fire && last_byte && !last_blk && !len_we && !cnt_we) |=>
        (cnt_live == $past(cnt_live) - 1'b1) && (len_live == $past(st_q.len_prog)));

    // R2: a count write reloads the byte counter from the programmed length
    assert_cnt_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && !len_we) |=> (len_live == $past(st_q.len_prog)) && (cnt_live == $past(field_plus1)));

    // R8: completion is flagged for a single cycle only
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

endmodule

// File: rtl/xps_packer.sv
module xps_packer
    import xps_pkg::*;
#(
    parameter int DEPTH  = XPS_DEPTH,
    parameter int BYTE_W = XPS_BYTE_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        xfer_active,
    input  logic                        xfer_dir,
    input  logic                        card_rx_valid,
    input  logic [BYTE_W-1:0]           card_rx_data,
    output logic                        card_rx_ready,
    output logic                        card_tx_valid,
    output logic [BYTE_W-1:0]           card_tx_data,
    input  logic                        card_tx_ready,
    input  logic [$clog2(DEPTH):0]      fifo_fill,
    input  logic [2*BYTE_W-1:0]         fifo_head,
    input  logic [$clog2(DEPTH)-1:0]    af_level,
    input  logic                        last_byte,
    input  logic                        blk_end,
    output logic                        byte_fire,
    output logic                        seq_push,
    output logic [2*BYTE_W-1:0]         seq_push_data,
    output logic                        seq_pop,
    output xps_mode_e                   mode
);

    localparam int FILL_W = $clog2(DEPTH) + 1;

    typedef struct packed {
        logic              run;
        logic              act_prev;
        logic              half;
        logic [BYTE_W-1:0] lo_byte;
        logic              hi_phase;
    } pack_state_t;

    pack_state_t st_q, st_d;
    logic        start, room, below_af, rx_fire, tx_fire;

    assign start    = xfer_active && !st_q.act_prev;
    assign room     = fifo_fill < FILL_W'(DEPTH);
    assign below_af = fifo_fill <= {1'b0, af_level};

    always_comb begin
        if (st_q.run && xfer_active) begin
            mode = xfer_dir ? XPS_RX : XPS_TX;
        end else begin
            mode = XPS_IDLE;
        end
    end

    assign card_rx_ready = (mode == XPS_RX) && room && (st_q.half || below_af);
    assign card_tx_valid = (mode == XPS_TX) && (fifo_fill != '0);
    assign card_tx_data  = st_q.hi_phase ? fifo_head[2*BYTE_W-1:BYTE_W]
                                         : fifo_head[BYTE_W-1:0];
    assign rx_fire       = card_rx_ready && card_rx_valid;
    assign tx_fire       = card_tx_valid && card_tx_ready;
    assign byte_fire     = rx_fire || tx_fire;

    always_comb begin
        st_d          = st_q;
        st_d.act_prev = xfer_active;
        seq_push      = 1'b0;
        seq_push_data = '0;
        seq_pop       = 1'b0;

        // Receive: pair bytes, low half first; a lone final byte goes out alone.
        if (rx_fire) begin
            if (st_q.half) begin
                seq_push      = 1'b1;
                seq_push_data = {card_rx_data, st_q.lo_byte};
                st_d.half     = 1'b0;
            end else if (last_byte) begin
                seq_push      = 1'b1;
                seq_push_data = {{BYTE_W{1'b0}}, card_rx_data};
            end else begin
                st_d.half    = 1'b1;
                st_d.lo_byte = card_rx_data;
            end
        end

        // Transmit: low half first; pop once the word or the block is used up.
        if (tx_fire) begin
            if (st_q.hi_phase || last_byte) begin
                seq_pop       = 1'b1;
                st_d.hi_phase = 1'b0;
            end else begin
                st_d.hi_phase = 1'b1;
            end
        end

        if (start) begin
            st_d.run      = 1'b1;
            st_d.half     = 1'b0;
            st_d.hi_phase = 1'b0;
        end else if (blk_end || !xfer_active) begin
            st_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9: nothing moves across the card port while the transfer is off
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active |-> !byte_fire);

    // R8: once the final byte has moved the port goes quiet
    assert_stop_after_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        blk_end |=> (!card_rx_ready && !card_tx_valid));

    // R5: a new word is not started while the FIFO sits above the level
    assert_rx_pause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fire && !st_q.half) |-> below_af);

    // R6: the card is never offered a byte from an empty FIFO
    assert_tx_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_fill == '0) |-> !card_tx_valid);

endmodule

// File: rtl/xfer_pack_seq.sv
module xfer_pack_seq
    import xps_pkg::*;
#(
    parameter int FIELD_W = XPS_FIELD_W,
    parameter int DEPTH   = XPS_DEPTH
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_len_we,
    input  logic                        cfg_cnt_we,
    input  logic [FIELD_W-1:0]          cfg_field,
    output logic [FIELD_W:0]            len_live,
    output logic [FIELD_W:0]            cnt_live,
    input  logic                        host_push,
    input  logic [XPS_WORD_W-1:0]       host_wdata,
    input  logic                        host_pop,
    output logic [XPS_WORD_W-1:0]       host_rdata,
    output logic [$clog2(DEPTH):0]      fifo_fill,
    input  logic [$clog2(DEPTH)-1:0]    af_level,
    input  logic                        xfer_active,
    input  logic                        xfer_dir,
    input  logic                        card_rx_valid,
    input  logic [XPS_BYTE_W-1:0]       card_rx_data,
    output logic                        card_rx_ready,
    output logic                        card_tx_valid,
    output logic [XPS_BYTE_W-1:0]       card_tx_data,
    input  logic                        card_tx_ready,
    output logic                        xfer_done
);

    localparam int FILL_W = $clog2(DEPTH) + 1;

    logic                   byte_fire, last_byte, blk_end;
    logic                   seq_push, seq_pop;
    logic [XPS_WORD_W-1:0]  seq_push_data;
    logic                   fifo_push, fifo_pop;
    logic [XPS_WORD_W-1:0]  fifo_wdata, fifo_head;
    logic [FILL_W-1:0]      fill;
    xps_mode_e              mode;

    // The sequencer owns the FIFO write side on receive and the read side on transmit.
    always_comb begin
        if (mode == XPS_RX) begin
            fifo_push  = seq_push;
            fifo_wdata = seq_push_data;
            fifo_pop   = host_pop;
        end else if (mode == XPS_TX) begin
            fifo_push  = host_push;
            fifo_wdata = host_wdata;
            fifo_pop   = seq_pop;
        end else begin
            fifo_push  = host_push;
            fifo_wdata = host_wdata;
            fifo_pop   = host_pop;
        end
    end

    xps_fifo #(
        .DEPTH  (DEPTH),
        .WORD_W (XPS_WORD_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (fifo_wdata),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .fill      (fill)
    );

    xps_counters #(
        .FIELD_W (FIELD_W)
    ) u_counters (
        .clk        (clk),
        .rst_n      (rst_n),
        .len_we     (cfg_len_we),
        .cnt_we     (cfg_cnt_we),
        .field      (cfg_field),
        .byte_fire  (byte_fire),
        .len_live   (len_live),
        .cnt_live   (cnt_live),
        .last_byte  (last_byte),
        .blk_end    (blk_end),
        .done_pulse (xfer_done)
    );

    xps_packer #(
        .DEPTH  (DEPTH),
        .BYTE_W (XPS_BYTE_W)
    ) u_packer (
        .clk           (clk),
        .rst_n         (rst_n),
        .xfer_active   (xfer_active),
        .xfer_dir      (xfer_dir),
        .card_rx_valid (card_rx_valid),
        .card_rx_data  (card_rx_data),
        .card_rx_ready (card_rx_ready),
        .card_tx_valid (card_tx_valid),
        .card_tx_data  (card_tx_data),
        .card_tx_ready (card_tx_ready),
        .fifo_fill     (fill),
        .fifo_head     (fifo_head),
        .af_level      (af_level),
        .last_byte     (last_byte),
        .blk_end       (blk_end),
        .byte_fire     (byte_fire),
        .seq_push      (seq_push),
        .seq_push_data (seq_push_data),
        .seq_pop       (seq_pop),
        .mode          (mode)
    );

    assign host_rdata = fifo_head;
    assign fifo_fill  = fill;

    // R10: host writes cannot slip into the FIFO while receive owns it
    assert_host_push_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == XPS_RX && host_push && !seq_push && !host_pop) |=> (fifo_fill == $past(fifo_fill)));

endmodule

// File: tb/xfer_pack_seq_tb.sv
module xfer_pack_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_len_we, cfg_cnt_we;
    logic [10:0] cfg_field;
    logic [11:0] len_live, cnt_live;
    logic        host_push, host_pop;
    logic [15:0] host_wdata, host_rdata;
    logic [5:0]  fifo_fill;
    logic [4:0]  af_level;
    logic        xfer_active, xfer_dir;
    logic        card_rx_valid, card_rx_ready;
    logic [7:0]  card_rx_data;
    logic        card_tx_valid, card_tx_ready;
    logic [7:0]  card_tx_data;
    logic        xfer_done;

    int n_chk = 0;
    int n_bad = 0;
    int done_cnt = 0;
    int m_len_prog, m_cnt_prog, m_len, m_cnt;
    logic [7:0] tx_seen [64];

    always #5 clk = ~clk;

    xfer_pack_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_len_we(cfg_len_we), .cfg_cnt_we(cfg_cnt_we), .cfg_field(cfg_field),
        .len_live(len_live), .cnt_live(cnt_live),
        .host_push(host_push), .host_wdata(host_wdata),
        .host_pop(host_pop), .host_rdata(host_rdata),
        .fifo_fill(fifo_fill), .af_level(af_level),
        .xfer_active(xfer_active), .xfer_dir(xfer_dir),
        .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data), .card_rx_ready(card_rx_ready),
        .card_tx_valid(card_tx_valid), .card_tx_data(card_tx_data), .card_tx_ready(card_tx_ready),
        .xfer_done(xfer_done)
    );

    always @(posedge clk) if (rst_n && xfer_done) done_cnt <= done_cnt + 1;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Bench model of the counters, advanced once per moved byte.
    task automatic model_step();
        if (m_len <= 1) begin
            m_len = m_len_prog;
            if (m_cnt <= 1) m_cnt = m_cnt_prog;
            else m_cnt--;
        end else begin
            m_len--;
        end
    endtask

    task automatic set_len(input int v);
        @(negedge clk); cfg_field = 11'(v); cfg_len_we = 1'b1;
        @(negedge clk); cfg_len_we = 1'b0;
        m_len_prog = v + 1; m_len = v + 1;
    endtask

    task automatic set_cnt(input int v);
        @(negedge clk); cfg_field = 11'(v); cfg_cnt_we = 1'b1;
        @(negedge clk); cfg_cnt_we = 1'b0;
        m_cnt_prog = v + 1; m_cnt = v + 1; m_len = m_len_prog;
    endtask

    task automatic push_word(input logic [15:0] w);
        @(negedge clk); host_wdata = w; host_push = 1'b1;
        @(negedge clk); host_push = 1'b0;
    endtask

    task automatic pop_check(input string req, input logic [15:0] exp);
        @(negedge clk);
        chk(req, "fifo word", 32'(host_rdata), 32'(exp));
        host_pop = 1'b1;
        @(negedge clk); host_pop = 1'b0;
    endtask

    task automatic begin_xfer(input logic dir);
        @(negedge clk); xfer_active = 1'b0;
        @(negedge clk); xfer_dir = dir; xfer_active = 1'b1;
    endtask

    task automatic end_xfer();
        @(negedge clk); xfer_active = 1'b0;
        @(negedge clk);
    endtask

    // Offer bytes first, first+1, ... until n are taken or the port stalls.
    task automatic rx_feed(input int n, input logic [7:0] first, output int got);
        int idle = 0;
        got = 0;
        while (got < n && idle < 8) begin
            @(negedge clk);
            chk("R11", "len_live during rx", 32'(len_live), 32'(m_len));
            chk("R7", "cnt_live during rx", 32'(cnt_live), 32'(m_cnt));
            card_rx_valid = 1'b1;
            card_rx_data  = first + 8'(got);
            if (card_rx_ready) begin
                @(posedge clk);
                got++; idle = 0; model_step();
            end else begin
                @(posedge clk);
                idle++;
            end
        end
        @(negedge clk); card_rx_valid = 1'b0;
    endtask

    task automatic tx_take(input int n, output int got);
        int idle = 0;
        got = 0;
        while (got < n && idle < 8) begin
            @(negedge clk);
            chk("R11", "len_live during tx", 32'(len_live), 32'(m_len));
            chk("R7", "cnt_live during tx", 32'(cnt_live), 32'(m_cnt));
            card_tx_ready = 1'b1;
            if (card_tx_valid) begin
                tx_seen[got] = card_tx_data;
                @(posedge clk);
                got++; idle = 0; model_step();
            end else begin
                @(posedge clk);
                idle++;
            end
        end
        @(negedge clk); card_tx_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11", "len_live after reset", 32'(len_live), 0);
        chk("R11", "cnt_live after reset", 32'(cnt_live), 0);
        chk("R9", "fifo_fill after reset", 32'(fifo_fill), 0);
        chk("R9", "rx_ready after reset", 32'(card_rx_ready), 0);
        chk("R9", "tx_valid after reset", 32'(card_tx_valid), 0);
        chk("R8", "done after reset", 32'(xfer_done), 0);
    endtask

    task automatic t_config();
        set_len(4);
        chk("R1", "len_live after length write", 32'(len_live), 5);
        set_cnt(1);
        chk("R2", "cnt_live after count write", 32'(cnt_live), 2);
        chk("R2", "len_live after count write", 32'(len_live), 5);
        set_len(10);
        chk("R1", "len_live after second length write", 32'(len_live), 11);
        set_cnt(0);
        chk("R11", "cnt_live readback", 32'(cnt_live), 1);
    endtask

    task automatic t_rx_even();
        int got, d0;
        set_len(3); set_cnt(1);
        d0 = done_cnt;
        begin_xfer(1'b1);
        rx_feed(8, 8'h11, got);
        chk("R3", "rx bytes taken", 32'(got), 8);
        repeat (3) @(negedge clk);
        chk("R8", "done pulses", 32'(done_cnt - d0), 1);
        chk("R8", "len reloaded", 32'(len_live), 4);
        chk("R8", "cnt reloaded", 32'(cnt_live), 2);
        chk("R8", "quiet after end", 32'(card_rx_ready), 0);
        chk("R3", "fill after rx", 32'(fifo_fill), 4);
        pop_check("R3", 16'h1211); pop_check("R3", 16'h1413);
        pop_check("R3", 16'h1615); pop_check("R3", 16'h1817);
        end_xfer();
    endtask

    task automatic t_rx_odd();
        int got, d0;
        set_len(2); set_cnt(1);
        d0 = done_cnt;
        begin_xfer(1'b1);
        rx_feed(6, 8'hA1, got);
        chk("R3", "rx odd bytes taken", 32'(got), 6);
        repeat (3) @(negedge clk);
        chk("R8", "done pulses odd", 32'(done_cnt - d0), 1);
        pop_check("R3", 16'hA2A1); pop_check("R3", 16'h00A3);
        pop_check("R3", 16'hA5A4); pop_check("R3", 16'h00A6);
        end_xfer();
    endtask

    task automatic t_rx_pause();
        int got, d0;
        @(negedge clk); af_level = 5'd1;
        set_len(7); set_cnt(0);
        d0 = done_cnt;
        begin_xfer(1'b1);
        rx_feed(8, 8'h40, got);
        chk("R5", "bytes before stall", 32'(got), 4);
        chk("R5", "fill at stall", 32'(fifo_fill), 2);
        chk("R5", "ready while above level", 32'(card_rx_ready), 0);
        pop_check("R5", 16'h4140);
        pop_check("R5", 16'h4342);
        rx_feed(4, 8'h44, got);
        chk("R5", "bytes after release", 32'(got), 4);
        repeat (3) @(negedge clk);
        chk("R8", "done after paced rx", 32'(done_cnt - d0), 1);
        pop_check("R3", 16'h4544); pop_check("R3", 16'h4746);
        end_xfer();
        @(negedge clk); af_level = 5'd31;
    endtask

    task automatic t_tx_even();
        int got, d0;
        set_len(3); set_cnt(0);
        push_word(16'h2211); push_word(16'h4433);
        d0 = done_cnt;
        begin_xfer(1'b0);
        tx_take(4, got);
        chk("R4", "tx bytes", 32'(got), 4);
        for (int i = 0; i < 4; i++) chk("R4", "tx even byte", 32'(tx_seen[i]), 32'(8'h11 + 8'(i * 8'h11)));
        repeat (3) @(negedge clk);
        chk("R8", "tx done", 32'(done_cnt - d0), 1);
        chk("R4", "fifo drained", 32'(fifo_fill), 0);
        end_xfer();
    endtask

    task automatic t_tx_odd();
        int got, d0;
        logic [7:0] exp [6];
        exp = '{8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'hEE, 8'hFF};
        set_len(2); set_cnt(1);
        push_word(16'hBBAA); push_word(16'h99CC); push_word(16'hEEDD); push_word(16'h88FF);
        d0 = done_cnt;
        begin_xfer(1'b0);
        tx_take(6, got);
        chk("R4", "tx odd bytes", 32'(got), 6);
        for (int i = 0; i < 6; i++) chk("R4", "tx odd byte", 32'(tx_seen[i]), 32'(exp[i]));
        repeat (3) @(negedge clk);
        chk("R8", "tx odd done", 32'(done_cnt - d0), 1);
        chk("R8", "tx quiet after end", 32'(card_tx_valid), 0);
        chk("R4", "fifo drained odd", 32'(fifo_fill), 0);
        end_xfer();
    endtask

    task automatic t_tx_pause();
        int got;
        set_len(1); set_cnt(0);
        begin_xfer(1'b0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R6", "tx_valid with empty fifo", 32'(card_tx_valid), 0);
        end
        push_word(16'h5655);
        chk("R6", "tx_valid after push", 32'(card_tx_valid), 1);
        tx_take(2, got);
        chk("R6", "tx bytes after pause", 32'(got), 2);
        chk("R4", "paused tx first byte", 32'(tx_seen[0]), 32'h55);
        chk("R4", "paused tx second byte", 32'(tx_seen[1]), 32'h56);
        end_xfer();
    endtask

    task automatic t_inactive();
        set_len(1); set_cnt(0);
        @(negedge clk); xfer_dir = 1'b1; xfer_active = 1'b0;
        card_rx_valid = 1'b1; card_rx_data = 8'h77;
        repeat (4) @(negedge clk);
        chk("R9", "ready while inactive", 32'(card_rx_ready), 0);
        chk("R9", "len unchanged while inactive", 32'(len_live), 2);
        chk("R9", "fill unchanged while inactive", 32'(fifo_fill), 0);
        card_rx_valid = 1'b0;
    endtask

    task automatic t_fifo_edges();
        int got;
        for (int i = 0; i < 33; i++) push_word(16'(16'h0100 + i));
        chk("R10", "fill capped when full", 32'(fifo_fill), 32);
        for (int i = 0; i < 32; i++) pop_check("R10", 16'(16'h0100 + i));
        @(negedge clk); host_pop = 1'b1;
        @(negedge clk); host_pop = 1'b0;
        chk("R10", "pop on empty", 32'(fifo_fill), 0);
        // host pop ignored during live transmit
        set_len(1); set_cnt(0);
        push_word(16'h7877);
        begin_xfer(1'b0);
        @(negedge clk); host_pop = 1'b1;
        @(negedge clk); host_pop = 1'b0;
        chk("R10", "host pop during tx", 32'(fifo_fill), 1);
        tx_take(2, got);
        chk("R10", "tx after blocked pop", 32'(tx_seen[1]), 32'h78);
        end_xfer();
        // host push ignored during live receive
        begin_xfer(1'b1);
        @(negedge clk);
        push_word(16'hDEAD);
        chk("R10", "host push during rx", 32'(fifo_fill), 0);
        rx_feed(2, 8'h30, got);
        chk("R10", "rx after blocked push", 32'(got), 2);
        pop_check("R3", 16'h3130);
        end_xfer();
    endtask

    initial begin
        rst_n = 1'b0;
        cfg_len_we = 0; cfg_cnt_we = 0; cfg_field = '0;
        host_push = 0; host_pop = 0; host_wdata = '0;
        af_level = 5'd31; xfer_active = 0; xfer_dir = 0;
        card_rx_valid = 0; card_rx_data = '0; card_tx_ready = 0;
        m_len_prog = 0; m_cnt_prog = 0; m_len = 0; m_cnt = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_rx_even();
        t_rx_odd();
        t_rx_pause();
        t_tx_even();
        t_tx_odd();
        t_tx_pause();
        t_inactive();
        t_fifo_edges();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule